// File: doc/BRIEF.md
# Clock Mode Selection Controller

This controller picks the operating mode of a clock-generation unit. A two-bit select field says which mode software asks for. Status flags decide whether the request can be granted now, later, or not at all. These flags are external-reference-valid, oscillator-stable, loss-of-clock and the lock indication from a separate lock detector. An off-request overrides everything. The controller gives three things:
- a 3-bit mode code;
- enables for the internal oscillator and the internal reference generator;
- a select that says whether the external reference or the internal oscillator drives the output clock.

The select field is encoded as follows: 2'b00 asks for self-clocked, 2'b01 for internal-reference FLL, 2'b10 for bypassed-external, and 2'b11 for external-reference FLL. Each FLL mode has an unlocked and a locked substate, and these follow the lock detector. When the oscillator clock is lost in the external FLL mode, the controller falls back to bypassed-external on its own, as long as the external reference is still good. When leaving the off state, the controller resumes from the select field and reference status it captured on the cycle it entered off.

Top module: `clk_mode_ctrl`

## Requirements
- R1: A low `rst_n` sampled on a rising edge puts the mode at self-clocked (code 3'd0), with `osc_en`=1, `refgen_en`=0 and `src_ext`=0.
- R2: The mode codes are: self-clocked 3'd0, internal FLL unlocked 3'd1, internal FLL locked 3'd2, external FLL unlocked 3'd3, external FLL locked 3'd4, bypassed-external 3'd5, off 3'd6. The mode changes at most once per rising edge and never shows codes 3'd7.
- R3: `off_req`=1 at a rising edge makes the next mode off (3'd6), whatever the current mode and the other inputs are.
- R4: From self-clocked, `sel`=2'b10 with `ref_ok`=1 moves to bypassed-external. With `ref_ok`=0 the mode stays self-clocked.
- R5: From self-clocked, `sel`=2'b11 moves to external FLL unlocked only when `ref_ok` and `osc_stable` are both 1. Otherwise the mode stays self-clocked.
- R6: From self-clocked, `sel`=2'b01 moves to internal FLL unlocked.
- R7: In either FLL mode, when the select still matches, `lock_ind`=1 gives the locked substate and `lock_ind`=0 gives the unlocked substate on the next edge.
- R8: In either external FLL substate, `clk_lost`=1 moves to bypassed-external if `ref_ok`=1, and to self-clocked if `ref_ok`=0. This takes priority over the select and lock inputs.
- R9: When leaving off (`off_req`=0), the mode goes to bypassed-external if the select captured on entry to off was 2'b10 with `ref_ok`=1. Otherwise it goes to self-clocked. A captured 2'b11 therefore waits in self-clocked until `osc_stable` rises.
- R10: From an FLL or bypass mode, a select that no longer names that mode returns to self-clocked. Bypassed-external also returns to self-clocked when `ref_ok` drops.
- R11: Outputs by mode:
  - self-clocked and external FLL: `osc_en`=1, `refgen_en`=0, `src_ext`=0;
  - internal FLL: `osc_en`=1, `refgen_en`=1, `src_ext`=0;
  - bypassed-external: `osc_en`=0, `refgen_en`=0, `src_ext`=1;
  - off: all three 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Requested mode select |
| ref_ok | input | 1 | External reference valid |
| osc_stable | input | 1 | Internal oscillator stable |
| clk_lost | input | 1 | Oscillator clock lost |
| lock_ind | input | 1 | Lock indication from the lock detector |
| off_req | input | 1 | Request to enter the off state |
| mode | output | 3 | Current mode code |
| osc_en | output | 1 | Internal oscillator enable |
| refgen_en | output | 1 | Internal reference generator enable |
| src_ext | output | 1 | 1 = external reference drives the output clock |

## Verification
The hardest situation to reach from the ports is leaving off after a captured 2'b11 request. The outcome depends on flags captured cycles earlier, and it also depends on when `osc_stable` rises after the exit. A long deterministic pseudo-random run covers this. It holds `sel` for several cycles at a time and pulses `off_req` at random, and a mirror model in the bench tracks the captured select and reference. A directed sequence then enters off with 2'b11, exits while the oscillator is not yet stable, and raises `osc_stable` later. The same random run also reaches the loss-of-clock fallback from both external FLL substates.

// File: rtl/clkm_pkg.sv
// Shared mode and select codes for the clock mode controller.
// Assumes a 3-bit mode code and a 2-bit select field.
package clkm_pkg;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        M_SELF     = 3'd0,
        M_INT_UNLK = 3'd1,
        M_INT_LOCK = 3'd2,
        M_EXT_UNLK = 3'd3,
        M_EXT_LOCK = 3'd4,
        M_BYPASS   = 3'd5,
        M_OFF      = 3'd6
    } mode_t;

    localparam logic [SEL_W-1:0] SEL_SELF = 2'b00;
    localparam logic [SEL_W-1:0] SEL_INT  = 2'b01;
    localparam logic [SEL_W-1:0] SEL_BYP  = 2'b10;
    localparam logic [SEL_W-1:0] SEL_EXT  = 2'b11;
endpackage

// File: rtl/clkm_next.sv
// Next-mode logic. It is purely combinational.
// Assumes the captured select and reference flags hold the values seen on entry to off.
module clkm_next
    import clkm_pkg::*;
(
    input  mode_t            cur,
    input  logic [SEL_W-1:0] sel,
    input  logic             ref_ok,
    input  logic             osc_stable,
    input  logic             clk_lost,
    input  logic             lock_ind,
    input  logic             off_req,
    input  logic [SEL_W-1:0] off_sel,
    input  logic             off_ref,
    output mode_t            nxt
);
    // Pick the next mode. off_req comes first, then clock loss, then select and lock.
    always_comb begin
        nxt = cur;
        if (off_req) begin
            nxt = M_OFF;
        end else begin
            unique case (cur)
                M_SELF: begin
                    if (sel == SEL_BYP && ref_ok)                      nxt = M_BYPASS;
                    else if (sel == SEL_EXT && ref_ok && osc_stable)   nxt = M_EXT_UNLK;
                    else if (sel == SEL_INT)                           nxt = M_INT_UNLK;
                    else                                               nxt = M_SELF;
                end
                M_INT_UNLK, M_INT_LOCK: begin
                    if (sel != SEL_INT)  nxt = M_SELF;
                    else if (lock_ind)   nxt = M_INT_LOCK;
                    else                 nxt = M_INT_UNLK;
                end
                M_EXT_UNLK, M_EXT_LOCK: begin
                    if (clk_lost)        nxt = ref_ok ? M_BYPASS : M_SELF;
                    else if (sel != SEL_EXT) nxt = M_SELF;
                    else if (lock_ind)   nxt = M_EXT_LOCK;
                    else                 nxt = M_EXT_UNLK;
                end
                M_BYPASS: begin
                    if (sel != SEL_BYP || !ref_ok) nxt = M_SELF;
                    else                           nxt = M_BYPASS;
                end
                M_OFF: begin
                    if (off_sel == SEL_BYP && off_ref) nxt = M_BYPASS;
                    else                               nxt = M_SELF;
                end
                default: nxt = M_SELF;
            endcase
        end
    end
endmodule

// File: rtl/clkm_outdec.sv
// Decodes the current mode into oscillator, reference-generator and source-select controls.
// Assumes the mode is one of the legal codes. Any other code decodes as off.
module clkm_outdec
    import clkm_pkg::*;
(
    input  mode_t m,
    output logic  osc_en,
    output logic  refgen_en,
    output logic  src_ext
);
    // Map each mode to its enable pattern.
    always_comb begin
        osc_en    = 1'b0;
        refgen_en = 1'b0;
        src_ext   = 1'b0;
        unique case (m)
            M_SELF, M_EXT_UNLK, M_EXT_LOCK: osc_en = 1'b1;
            M_INT_UNLK, M_INT_LOCK: begin
                osc_en    = 1'b1;
                refgen_en = 1'b1;
            end
            M_BYPASS: src_ext = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/clk_mode_ctrl.sv
// Top level of the clock mode controller. It holds the mode register and the
// select/reference capture taken on entry to off.
// Assumes the status flags are already synchronous to clk.
module clk_mode_ctrl
    import clkm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic                ref_ok,
    input  logic                osc_stable,
    input  logic                clk_lost,
    input  logic                lock_ind,
    input  logic                off_req,
    output logic [MODE_W-1:0]   mode,
    output logic                osc_en,
    output logic                refgen_en,
    output logic                src_ext
);
    mode_t            mode_q;
    mode_t            mode_d;
    logic [SEL_W-1:0] off_sel_q;
    logic             off_ref_q;

    clkm_next u_next (
        .cur(mode_q), .sel(sel), .ref_ok(ref_ok), .osc_stable(osc_stable),
        .clk_lost(clk_lost), .lock_ind(lock_ind), .off_req(off_req),
        .off_sel(off_sel_q), .off_ref(off_ref_q), .nxt(mode_d)
    );

    // Mode register with synchronous reset to self-clocked.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= M_SELF;
        else        mode_q <= mode_d;
    end

    // Capture the select and reference status on the edge that enters off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_sel_q <= SEL_SELF;
            off_ref_q <= 1'b0;
        end else if (mode_d == M_OFF && mode_q != M_OFF) begin
            off_sel_q <= sel;
            off_ref_q <= ref_ok;
        end
    end

    clkm_outdec u_dec (
        .m(mode_q), .osc_en(osc_en), .refgen_en(refgen_en), .src_ext(src_ext)
    );

    assign mode = mode_q;
endmodule

// File: rtl/clkm_chk.sv
// Assertion checker for clk_mode_ctrl. It watches the top-level ports only.
// It is attached to the top module by the bind statement at the end of this file.
module clkm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       ref_ok,
    input logic       osc_stable,
    input logic       clk_lost,
    input logic       lock_ind,
    input logic       off_req,
    input logic [2:0] mode,
    input logic       osc_en,
    input logic       refgen_en,
    input logic       src_ext
);
    p_reset_self_r1: assert property (@(posedge clk) !rst_n |=> (mode == 3'd0 && osc_en && !refgen_en && !src_ext));

    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n) mode != 3'd7);

    p_off_priority_r3: assert property (@(posedge clk) disable iff (!rst_n) off_req |=> mode == 3'd6);

    p_bypass_needs_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !off_req && sel == 2'b10 && !ref_ok) |=> mode == 3'd0);

    p_ext_needs_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !off_req && sel == 2'b11 && !osc_stable) |=> mode == 3'd0);

    p_int_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd1 || mode == 3'd2) && !off_req && sel == 2'b01 && lock_ind) |=> mode == 3'd2);

    p_loss_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd3 || mode == 3'd4) && !off_req && clk_lost && ref_ok) |=> mode == 3'd5);

    p_bypass_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5) |-> (!osc_en && !refgen_en && src_ext));

    p_off_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> (!osc_en && !refgen_en && !src_ext));
endmodule

bind clk_mode_ctrl clkm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ref_ok(ref_ok), .osc_stable(osc_stable),
    .clk_lost(clk_lost), .lock_ind(lock_ind), .off_req(off_req), .mode(mode),
    .osc_en(osc_en), .refgen_en(refgen_en), .src_ext(src_ext)
);

// File: tb/sim_clk_mode_ctrl.sv
// Bench for clk_mode_ctrl. It runs a long pseudo-random stimulus against a
// reference model written from the requirements, then directed sequences.
module sim_clk_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       ref_ok = 1'b0, osc_stable = 1'b0, clk_lost = 1'b0, lock_ind = 1'b0, off_req = 1'b0;
    logic [2:0] mode;
    logic       osc_en, refgen_en, src_ext;

    int errors = 0;
    int checks = 0;
    logic [2:0]  exp_mode = 3'd0;
    logic [1:0]  exp_lsel = 2'b00;
    logic        exp_lref = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [6:0]  seen = '0;

    always #2 clk = ~clk;

    clk_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ref_ok(ref_ok), .osc_stable(osc_stable),
        .clk_lost(clk_lost), .lock_ind(lock_ind), .off_req(off_req), .mode(mode),
        .osc_en(osc_en), .refgen_en(refgen_en), .src_ext(src_ext)
    );

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [2:0] f_next(input logic [2:0] m, input logic [1:0] s,
        input logic r, input logic st, input logic lo, input logic lk, input logic off,
        input logic [1:0] ls, input logic lr);
        if (off) return 3'd6;
        case (m)
            3'd0: begin
                if (s == 2'b10) return r ? 3'd5 : 3'd0;
                if (s == 2'b11) return (r && st) ? 3'd3 : 3'd0;
                if (s == 2'b01) return 3'd1;
                return 3'd0;
            end
            3'd1, 3'd2: return (s != 2'b01) ? 3'd0 : (lk ? 3'd2 : 3'd1);
            3'd3, 3'd4: begin
                if (lo) return r ? 3'd5 : 3'd0;
                return (s != 2'b11) ? 3'd0 : (lk ? 3'd4 : 3'd3);
            end
            3'd5: return (s != 2'b10 || !r) ? 3'd0 : 3'd5;
            default: return (ls == 2'b10 && lr) ? 3'd5 : 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] f_outs(input logic [2:0] m);
        // {osc_en, refgen_en, src_ext} per R11
        case (m)
            3'd0, 3'd3, 3'd4: return 3'b100;
            3'd1, 3'd2:       return 3'b110;
            3'd5:             return 3'b001;
            default:          return 3'b000;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Apply one set of inputs, advance one edge, update the model and compare.
    task automatic step(input logic [1:0] s, input logic r, input logic st, input logic lo,
                        input logic lk, input logic off);
        string tag;
        logic [2:0] prev;
        @(negedge clk);
        sel = s; ref_ok = r; osc_stable = st; clk_lost = lo; lock_ind = lk; off_req = off;
        @(posedge clk);
        #1;
        prev = exp_mode;
        if (!rst_n) begin
            exp_mode = 3'd0; exp_lsel = 2'b00; exp_lref = 1'b0; tag = "R1";
        end else begin
            exp_mode = f_next(prev, s, r, st, lo, lk, off, exp_lsel, exp_lref);
            if (exp_mode == 3'd6 && prev != 3'd6) begin exp_lsel = s; exp_lref = r; end
            if (off) tag = "R3";
            else if (prev == 3'd6) tag = "R9";
            else if (prev == 3'd0) tag = (s == 2'b10) ? "R4" : (s == 2'b11) ? "R5" : "R6";
            else if (prev == 3'd3 || prev == 3'd4) tag = lo ? "R8" : "R7";
            else if (prev == 3'd5) tag = "R10";
            else tag = "R7";
        end
        check(tag, mode, exp_mode);
        check("R11", {osc_en, refgen_en, src_ext}, f_outs(exp_mode));
        if (mode != 3'd7) seen[mode] = 1'b1;
        else check("R2", mode, 3'd0);
    endtask

    initial begin
        logic [1:0] hs;
        hs = 2'b00;
        // R1: reset state
        step(2'b11, 1, 1, 0, 1, 0);
        step(2'b10, 1, 1, 0, 1, 0);
        rst_n = 1'b1;
        // Pseudo-random sweep with sticky select and rare off requests
        for (int i = 0; i < 20000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) hs = lfsr[4:3];
            step(hs, lfsr[5] | lfsr[6], lfsr[7], (lfsr[10:8] == 3'd0), lfsr[11],
                 (lfsr[15:12] == 4'd0));
        end
        // R2: every legal mode code was visited
        check("R2", {2'b00, &seen}, 3'd1);
        // R9: enter off with select 2'b11, leave before the oscillator is stable
        step(2'b00, 0, 0, 0, 0, 0);
        step(2'b11, 1, 0, 0, 0, 1);
        step(2'b11, 1, 0, 0, 0, 1);
        step(2'b11, 1, 0, 0, 0, 0);
        check("R9", mode, 3'd0);
        step(2'b11, 1, 0, 0, 0, 0);
        step(2'b11, 1, 1, 0, 0, 0);
        check("R9", mode, 3'd3);
        // R9: enter off with 2'b10 and a valid reference, then exit to bypass
        step(2'b10, 1, 0, 0, 0, 1);
        step(2'b00, 0, 0, 0, 0, 0);
        check("R9", mode, 3'd5);
        // R8: loss of clock from the locked external mode
        step(2'b11, 1, 1, 0, 0, 0);
        step(2'b11, 1, 1, 0, 0, 0);
        step(2'b11, 1, 1, 0, 1, 0);
        check("R7", mode, 3'd4);
        step(2'b11, 1, 1, 1, 1, 0);
        check("R8", mode, 3'd5);
        // R1: reset from bypass
        rst_n = 1'b0;
        step(2'b10, 1, 1, 0, 0, 0);
        rst_n = 1'b1;
        check("R1", mode, 3'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule